// File: doc/BRIEF.md
# Wilkinson ADC Conversion Window Controller

This block opens and closes the conversion-enable window of a ramp-and-count ADC. A start strobe opens the window. The window first stays high for a programmable number of setup cycles. After that, a conversion counter runs. The counter scores two codes per ADC clock period, one for each clock edge, so a full-scale conversion of n bits takes 2^(n-1) clock periods instead of 2^n. The resolution is picked from 9, 10, 11 or 12 bits.

The window closes in one of three ways: the conversion reaches full scale, the comparator signals that the ramp crossed the input, or a watchdog expires. The watchdog counts the slower beam-clock ticks while the window is open and aborts it at a fixed limit. At the default limit with four ADC clocks per beam tick, this cuts 11-bit and 12-bit conversions short of full scale. The digitized code, a done pulse or a timeout pulse is presented when the window closes, and the code is then held until the next window closes.

Top module: `wconv_window`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it is released, `win_o`, `done_o` and `tout_o` are low and `code_o` is zero.
- R2: A start strobe accepted while the block is idle raises `win_o` in the next cycle. At that strobe the block latches the resolution select (2'b00 = 9 bits, 2'b01 = 10, 2'b10 = 11, 2'b11 = 12) and the setup count.
- R3: The window first stays high for exactly the latched setup count of cycles with the conversion counter idle. A setup count of zero starts counting in the first window cycle.
- R4: When nothing cuts it short, the window lasts the setup count plus 2^(n-1) cycles. It then ends with a done pulse and code 2^n-1.
- R5: If `cmp_stop_i` is high in conversion cycle j (j counted from 0), the window ends after that cycle with code 2*j + `cmp_half_i`. `cmp_stop_i` has no effect during setup cycles.
- R6: Beam ticks are counted only in cycles where `win_o` is high. When the 200th such tick arrives, the window ends after that cycle with a timeout pulse instead of done. The code is then 2*j for conversion cycle j, or 0 if the tick fell in setup. A timeout takes precedence over a comparator stop or full scale in the same cycle.
- R7: Each window ends with exactly one of `done_o` or `tout_o`. That flag is a single-cycle pulse in the first cycle in which `win_o` is low again.
- R8: `code_o` changes only when a done or timeout pulse is raised, and holds its value in between.
- R9: A start strobe while the window is open is ignored. Changes to the resolution select or the setup count during the window have no effect on that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | ADC clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle conversion start strobe |
| res_sel_i | input | 2 | Resolution select, latched at start |
| ovh_i | input | OVH_W | Setup overhead in ADC clock cycles, latched at start |
| beam_tick_i | input | 1 | Single-cycle beam-clock tick, synchronous to clk_i |
| cmp_stop_i | input | 1 | Comparator crossing seen in this cycle |
| cmp_half_i | input | 1 | The crossing came after the falling edge of this cycle |
| win_o | output | 1 | Conversion-enable window |
| code_o | output | CODE_W | Digitized count, held between window ends |
| done_o | output | 1 | Pulse: window ended normally |
| tout_o | output | 1 | Pulse: window aborted by the beam watchdog |

## Verification
The assertions assume that `start_i` is a single-cycle strobe that never arrives during reset. They also assume that beam ticks are single-cycle pulses already in the ADC clock domain, and that the comparator inputs are only acted on inside the window. The stimulus drives every input at the falling edge. Start comes from a driver task only when the block is idle, except for the deliberate mid-window strobes that test R9. Ticks follow fixed periods of one or four cycles, or are absent. Comparator stops are held high through setup on purpose, and the stimulus cuts the window before the watchdog can see a tick outside it.

// File: rtl/wconv_pkg.sv
package wconv_pkg;

  typedef enum logic [1:0] {
    WC_IDLE  = 2'd0,
    WC_SETUP = 2'd1,
    WC_CONV  = 2'd2
  } wc_state_e;

  localparam int unsigned WC_RES_MIN = 9;

  // Resolution in bits for a select value.
  function automatic int unsigned wc_res_bits(input logic [1:0] sel);
    return WC_RES_MIN + int'(unsigned'(sel));
  endfunction

  // Index of the last conversion cycle: two codes per clock period.
  function automatic int unsigned wc_last_cycle(input logic [1:0] sel);
    return (32'd1 << (wc_res_bits(sel) - 1)) - 32'd1;
  endfunction

  // Code reported on reaching full scale.
  function automatic int unsigned wc_full_code(input logic [1:0] sel);
    return (32'd1 << wc_res_bits(sel)) - 32'd1;
  endfunction

endpackage

// File: rtl/wconv_setup_timer.sv
module wconv_setup_timer #(
  parameter int OVH_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [OVH_W-1:0] ovh_i,
  input  logic             run_i,
  output logic             last_o
);

  logic [OVH_W-1:0] rem_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= ovh_i;
    end else if (run_i && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // Final setup cycle: one remaining.
  assign last_o = run_i && (rem_q == OVH_W'(1));

endmodule

// File: rtl/wconv_dual_cnt.sv
module wconv_dual_cnt #(
  parameter int CYC_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CYC_W-1:0] last_cyc_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic             at_last_o
);

  logic [CYC_W-1:0] cyc_q;

  // Whole-period counter. The half-period (falling edge) bit is
  // appended by the owner at the moment the window closes.
  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cyc_q <= '0;
    end else if (clr_i) begin
      cyc_q <= '0;
    end else if (adv_i && cyc_q != last_cyc_i) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign cyc_o     = cyc_q;
  assign at_last_o = (cyc_q == last_cyc_i);

endmodule

// File: rtl/wconv_beam_wdog.sv
module wconv_beam_wdog #(
  parameter int LIMIT = 200,
  parameter int WD_W  = $clog2(LIMIT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            clr_i,
  input  logic            arm_i,
  input  logic            tick_i,
  output logic            expire_o,
  output logic [WD_W-1:0] cnt_o
);

  logic [WD_W-1:0] cnt_q;
  logic            tick_in;

  assign tick_in  = arm_i && tick_i;
  assign expire_o = tick_in && (cnt_q == WD_W'(LIMIT - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_in && cnt_q != WD_W'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wconv_window.sv
module wconv_window
  import wconv_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int OVH_W      = 8,
  parameter int WDOG_LIMIT = 200
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic [1:0]        res_sel_i,
  input  logic [OVH_W-1:0]  ovh_i,
  input  logic              beam_tick_i,
  input  logic              cmp_stop_i,
  input  logic              cmp_half_i,
  output logic              win_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              tout_o
);

  localparam int CYC_W = CODE_W - 1;
  localparam int WD_W  = $clog2(WDOG_LIMIT + 1);

  wc_state_e        state_q, state_d;
  logic [1:0]       res_q;
  logic [CODE_W-1:0] code_q;
  logic             done_q, tout_q;

  // Named internal events
  logic             start_acc;
  logic             in_setup, in_conv, win_open;
  logic             setup_last;
  logic             cnv_full, cnv_stop;
  logic             wd_expire;
  logic             end_done, end_tout;
  logic [CYC_W-1:0] cyc_cnt;
  logic [CYC_W-1:0] last_cyc;
  logic [WD_W-1:0]  wd_cnt;
  logic             at_last;

  assign in_setup  = (state_q == WC_SETUP);
  assign in_conv   = (state_q == WC_CONV);
  assign win_open  = in_setup || in_conv;
  assign start_acc = start_i && (state_q == WC_IDLE);
  assign last_cyc  = CYC_W'(wc_last_cycle(res_q));

  wconv_setup_timer #(.OVH_W(OVH_W)) u_setup (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (start_acc),
    .ovh_i   (ovh_i),
    .run_i   (in_setup),
    .last_o  (setup_last)
  );

  wconv_dual_cnt #(.CYC_W(CYC_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .clr_i      (start_acc),
    .adv_i      (in_conv),
    .last_cyc_i (last_cyc),
    .cyc_o      (cyc_cnt),
    .at_last_o  (at_last)
  );

  wconv_beam_wdog #(.LIMIT(WDOG_LIMIT), .WD_W(WD_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .clr_i    (start_acc),
    .arm_i    (win_open),
    .tick_i   (beam_tick_i),
    .expire_o (wd_expire),
    .cnt_o    (wd_cnt)
  );

  assign cnv_full = in_conv && at_last;
  assign cnv_stop = in_conv && cmp_stop_i;
  // Watchdog outranks every normal ending in the same cycle.
  assign end_tout = wd_expire;
  assign end_done = !wd_expire && (cnv_stop || cnv_full);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WC_IDLE: begin
        if (start_acc) state_d = (ovh_i == '0) ? WC_CONV : WC_SETUP;
      end
      WC_SETUP: begin
        if (end_tout)        state_d = WC_IDLE;
        else if (setup_last) state_d = WC_CONV;
      end
      WC_CONV: begin
        if (end_tout || end_done) state_d = WC_IDLE;
      end
      default: state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      state_q <= WC_IDLE;
      res_q   <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= end_done;
      tout_q  <= end_tout;
      if (start_acc) res_q <= res_sel_i;
      if (end_tout) begin
        code_q <= {cyc_cnt, 1'b0};
      end else if (end_done) begin
        code_q <= {cyc_cnt, (cnv_stop ? cmp_half_i : 1'b1)};
      end
    end
  end

  assign win_o  = win_open;
  assign code_o = code_q;
  assign done_o = done_q;
  assign tout_o = tout_q;

endmodule

// File: rtl/wconv_window_chk.sv
module wconv_window_chk
  import wconv_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int WDOG_LIMIT = 200,
  parameter int WD_W       = 8
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              start_i,
  input logic              win_o,
  input logic [CODE_W-1:0] code_o,
  input logic              done_o,
  input logic              tout_o,
  input logic [1:0]        res_q,
  input logic [WD_W-1:0]   wd_cnt
);

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$past(rst_n_i) |-> (!win_o && !done_o && !tout_o && code_o == '0)); // R1

  AST_WIN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i) && $past(start_i) && !$past(win_o)) |-> win_o); // R2

  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (win_o && $past(win_o)) |-> $stable(res_q)); // R9

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> (code_o <= CODE_W'(wc_full_code(res_q)))); // R4

  AST_WDOG_CAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wd_cnt <= WD_W'(WDOG_LIMIT)); // R6

  AST_TOUT_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tout_o |-> (wd_cnt == WD_W'(WDOG_LIMIT))); // R6

  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(done_o && tout_o)); // R7

  AST_FALL_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(win_o) |-> (done_o || tout_o)); // R7

  AST_FLAG_AFTER_WIN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o || tout_o) |-> (!win_o && $past(win_o))); // R7

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i) && !done_o && !tout_o) |-> $stable(code_o)); // R8

endmodule

bind wconv_window wconv_window_chk #(
  .CODE_W     (CODE_W),
  .WDOG_LIMIT (WDOG_LIMIT),
  .WD_W       (WD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .start_i (start_i),
  .win_o   (win_o),
  .code_o  (code_o),
  .done_o  (done_o),
  .tout_o  (tout_o),
  .res_q   (res_q),
  .wd_cnt  (wd_cnt)
);

// File: tb/wconv_window_bench.sv
module wconv_window_bench;

  localparam int CODE_W = 12;
  localparam int OVH_W  = 8;
  localparam int LIMIT  = 200;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i, beam_tick_i, cmp_stop_i, cmp_half_i;
  logic [1:0]        res_sel_i;
  logic [OVH_W-1:0]  ovh_i;
  logic              win_o, done_o, tout_o;
  logic [CODE_W-1:0] code_o;

  always #2 clk = ~clk;

  wconv_window #(.CODE_W(CODE_W), .OVH_W(OVH_W), .WDOG_LIMIT(LIMIT)) u_wconv_window (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .start_i     (start_i),
    .res_sel_i   (res_sel_i),
    .ovh_i       (ovh_i),
    .beam_tick_i (beam_tick_i),
    .cmp_stop_i  (cmp_stop_i),
    .cmp_half_i  (cmp_half_i),
    .win_o       (win_o),
    .code_o      (code_o),
    .done_o      (done_o),
    .tout_o      (tout_o)
  );

  typedef struct {
    int    len;
    bit    tout;
    int    code;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures the window and scores the ending against the queue.
  int cur_len = 0;
  bit prev_flag = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_flag) check(!done_o && !tout_o, "R7", "flag width", int'(done_o | tout_o), 0);
      if (win_o) cur_len++;
      if (done_o || tout_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected end", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(!(done_o && tout_o) && (tout_o == e.tout), e.req, "end kind",
                int'({done_o, tout_o}), e.tout ? 1 : 2);
          check(cur_len == e.len, e.req, "window length", cur_len, e.len);
          check(int'(code_o) == e.code, e.req, "code", int'(code_o), e.code);
        end
        cur_len = 0;
      end
      prev_flag = done_o || tout_o;
    end
  end

  // Driver: predicts the ending from the requirements, then plays the window.
  // per: beam tick every per cycles (0 = none); stop_j < 0: no comparator stop;
  // restart_at >= 0: extra start with altered select/overhead at that cycle.
  task automatic run_win(input int sel, input int ovh, input int per,
                         input int stop_j, input bit half, input int restart_at,
                         input string req);
    exp_t e;
    int   n      = 9 + sel;
    int   last_j = (1 << (n - 1)) - 1;
    int   ticks  = 0;
    e.req = req;
    for (int i = 0; i < 100000; i++) begin
      bit tk = (per > 0) && ((i % per) == per - 1);
      if (tk) ticks++;
      if (ticks == LIMIT) begin
        e.tout = 1; e.len = i + 1; e.code = (i >= ovh) ? 2 * (i - ovh) : 0;
        break;
      end
      if (i >= ovh) begin
        int j = i - ovh;
        if (j == stop_j) begin
          e.tout = 0; e.len = i + 1; e.code = 2 * j + int'(half); break;
        end
        if (j == last_j) begin
          e.tout = 0; e.len = i + 1; e.code = (1 << n) - 1; break;
        end
      end
    end
    exp_q.push_back(e);

    @(negedge clk);
    start_i     = 1'b1;
    res_sel_i   = 2'(sel);
    ovh_i       = OVH_W'(ovh);
    beam_tick_i = 1'b1;   // tick outside the window: not counted (R6)
    cmp_stop_i  = 1'b0;
    cmp_half_i  = half;
    for (int i = 0; i < e.len; i++) begin
      @(negedge clk);
      start_i     = (i == restart_at);
      if (i == restart_at) begin
        res_sel_i = ~2'(sel);
        ovh_i     = OVH_W'(ovh + 7);
      end
      beam_tick_i = (per > 0) && ((i % per) == per - 1);
      cmp_stop_i  = (stop_j >= 0) && ((i < ovh) || (i - ovh == stop_j));
    end
    @(negedge clk);
    start_i = 0; beam_tick_i = 0; cmp_stop_i = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start_i = 0; beam_tick_i = 0; cmp_stop_i = 0; cmp_half_i = 0;
    res_sel_i = 0; ovh_i = 0;
    repeat (4) @(negedge clk);
    check(!win_o && !done_o && !tout_o, "R1", "flags in reset", int'({win_o, done_o, tout_o}), 0);
    check(code_o == 0, "R1", "code in reset", int'(code_o), 0);
    rst_n = 1;
    @(negedge clk);
    check(!win_o && code_o == 0, "R1", "after release", int'(code_o), 0);

    run_win(0, 5, 4, -1, 0, -1, "R4");     // 9 bits, full scale
    run_win(1, 0, 4, -1, 0, -1, "R3");     // 10 bits, no setup
    run_win(2, 3, 4, -1, 0, -1, "R6");     // 11 bits, cut by watchdog
    run_win(3, 2, 4, -1, 0, -1, "R6");     // 12 bits, cut by watchdog
    run_win(0, 6, 0, 37, 1, -1, "R5");     // stop, upper half
    run_win(1, 4, 0, 100, 0, -1, "R5");    // stop, lower half
    begin
      logic [CODE_W-1:0] held;
      held = code_o;
      cmp_stop_i = 1; beam_tick_i = 1;
      repeat (6) @(negedge clk);
      cmp_stop_i = 0; beam_tick_i = 0;
      check(code_o == held && !win_o, "R8", "code held while idle", int'(code_o), int'(held));
    end
    run_win(1, 250, 1, -1, 0, -1, "R6");   // timeout inside setup
    run_win(0, 4, 0, -1, 0, 50, "R9");     // restart strobe ignored
    run_win(3, 0, 1, 199, 1, -1, "R6");    // timeout beats stop same cycle
    run_win(2, 1, 0, -1, 0, -1, "R2");     // 11 bits, no ticks: full scale
    run_win(3, 0, 0, -1, 0, -1, "R4");     // 12 bits full scale

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pending ends", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog expired: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule